// File: doc/BRIEF.md
# I2C register-file slave with latched status

This block is a serial-bus slave for a flash-driver controller. It oversamples the two bus lines with the system clock, finds START and STOP conditions, answers one of four 7-bit slave addresses picked by a 2-bit strap, and serves a map of four byte registers. Three of them (command, dimming, auxiliary) are read/write and drive the rest of the chip. The fourth is a read-only status byte. It holds a live run indication and five fault flags that latch when raised.

Every transfer starts with the address byte. A write continues with a register pointer byte and then data bytes. A read first sets the pointer in a write phase, then sends a repeated START with the read bit set. The pointer steps by one after every data byte moved in either direction and wraps from 3 to 0, so bursts need no re-addressing. The pointer persists between transfers. When the status byte is read, its latched flags are cleared and the active-low attention output goes high again.

The protocol engine is a single state machine. Its states are:
- `ST_IDLE`: waiting for a START.
- `ST_DEV`: shifting in the address byte.
- `ST_DEV_ACK`: acknowledging the address.
- `ST_PTR` and `ST_PTR_ACK`: taking in and acknowledging the pointer byte.
- `ST_WR` and `ST_WR_ACK`: taking in and acknowledging a data byte.
- `ST_RD`: shifting a byte out.
- `ST_RD_ACK`: sampling the master's acknowledge.
- `ST_SKIP`: ignoring the bus until the next START or STOP.

A START moves any state to `ST_DEV`, and a STOP moves any state to `ST_IDLE`. The other transitions are:
- `ST_DEV` goes to `ST_DEV_ACK` when the address matches, or to `ST_SKIP` when it does not.
- `ST_DEV_ACK` goes to `ST_RD` or `ST_PTR`, depending on the R/W bit.
- `ST_PTR` goes to `ST_PTR_ACK`, which goes to `ST_WR`.
- `ST_WR` and `ST_WR_ACK` alternate.
- `ST_RD` goes to `ST_RD_ACK`. That state goes back to `ST_RD` when the master acknowledges, or to `ST_SKIP` when it does not.

Top module: `i2c_regmap_slave`

## Requirements
- R1: After reset, the command, dimming and auxiliary outputs are 0x00, `attn_n_o` is 1 and `sda_oe_o` is 0.
- R2: The slave acknowledges an address byte whose upper 7 bits equal 0b01100 followed by `addr_sel_i[1:0]` (0x30 to 0x33). It does so by asserting `sda_oe_o`, which pulls SDA low, for the ninth clock of that byte.
- R3: For any other address, the slave gives no acknowledge on any byte and changes no register until the next START.
- R4: In a write, the byte after the address byte is the register pointer. Each following data byte, received MSB first, is stored at the pointer: 0 is command, 1 is dimming, 2 is auxiliary.
- R5: The pointer increments after every data byte written or read and wraps from 3 to 0. Only bits [1:0] of the pointer byte are used.
- R6: After a repeated START with R/W = 1, the slave sends registers MSB first from the pointer. A master ACK continues the read. A NACK ends it, and the slave leaves SDA released until the next START or STOP.
- R7: The pointer is kept between transfers, so a read with no pointer phase starts at the current pointer.
- R8: Register 3 (status) ignores writes, but a write to it still advances the pointer.
- R9: The status byte is: bit 7 = 0, bit 6 = `run_i` (live), bit 5 = LED fault, bit 4 = temperature warning, bit 3 = temperature high, bit 2 = chip overtemperature, bit 1 = 0, bit 0 = output voltage not good. The last five come from `flt_set_i` bits 4, 3, 2, 1 and 0 in that order.
- R10: A fault flag latches on its `flt_set_i` bit and holds until the status register is read. The read returns the value before clearing. A set in the same cycle as the clear wins.
- R11: `attn_n_o` is 0 while any fault flag is latched and returns to 1 after the status read that clears them.
- R12: A START or STOP in the middle of a byte discards the partial byte, and no register is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Active-low reset |
| addr_sel_i | input | 2 | Strap selecting the low two address bits |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | Open-drain enable; 1 pulls SDA low |
| run_i | input | 1 | Live run indication shown in status bit 6 |
| flt_set_i | input | 5 | Fault set events (LED, temp warn, temp high, overtemp, vout not good) |
| cmd_o | output | 8 | Command register |
| dim_o | output | 8 | Dimming register |
| aux_o | output | 8 | Auxiliary register |
| attn_n_o | output | 1 | Active-low attention, low while any fault is latched |

## Verification
The hardest case to reach from the ports is a fault being raised in the same cycle as the status read that clears the flags. The bench holds two fault inputs high for the whole status read, so the set and the clear are bound to overlap. It then checks that the byte read back shows them, that attention stays low, and that the next read still returns them. Wrap-around is reached with a four-byte write burst starting at pointer 1, which passes over the read-only status slot. Pointer persistence is reached with reads that carry no pointer phase.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
    localparam int unsigned BYTE_W   = 8;
    localparam int unsigned NREG     = 4;
    localparam int unsigned PTR_W    = $clog2(NREG);
    localparam int unsigned STAT_IDX = NREG - 1;
    localparam int unsigned FLAG_N   = 5;
    localparam int unsigned SEL_W    = 2;
    localparam int unsigned DADDR_W  = 7;
    localparam int unsigned CNT_W    = $clog2(BYTE_W + 1);

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_RD,
        ST_RD_ACK,
        ST_SKIP
    } bus_st_t;
endpackage

// File: rtl/i2cs_line_sync.sv
module i2cs_line_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_ff;
    logic [STAGES-1:0] sda_ff;
    logic              scl_p;
    logic              sda_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_p  <= 1'b1;
            sda_p  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[STAGES-2:0], scl_i};
            sda_ff <= {sda_ff[STAGES-2:0], sda_i};
            scl_p  <= scl_ff[STAGES-1];
            sda_p  <= sda_ff[STAGES-1];
        end
    end

    assign scl_s     = scl_ff[STAGES-1];
    assign sda_s     = sda_ff[STAGES-1];
    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    // data edges while the clock line stays high mark bus conditions
    assign start_det = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2cs_regfile.sv
module i2cs_regfile
    import i2cs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  ptr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              rd_stb,
    input  logic              run_i,
    input  logic [FLAG_N-1:0] flt_set_i,
    output logic [BYTE_W-1:0] rd_data,
    output logic [BYTE_W-1:0] cmd_q,
    output logic [BYTE_W-1:0] dim_q,
    output logic [BYTE_W-1:0] aux_q,
    output logic [FLAG_N-1:0] flags,
    output logic              attn_n
);
    logic [BYTE_W-1:0] rw_flat [STAT_IDX];
    logic [BYTE_W-1:0] stat_byte;
    logic              stat_clr;
    logic [FLAG_N-1:0] flags_d;

    for (genvar gi = 0; gi < STAT_IDX; gi++) begin : g_rw
        logic [BYTE_W-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                q <= '0;
            else if (wr_en && ptr == PTR_W'(gi))
                q <= wr_data;
        end
        assign rw_flat[gi] = q;
    end

    assign cmd_q = rw_flat[0];
    assign dim_q = rw_flat[1];
    assign aux_q = rw_flat[2];

    // status: 0, run, led, ntc warn, ntc hot, overtemp, 0, vout low
    assign stat_byte = {1'b0, run_i, flags[4:1], 1'b0, flags[0]};

    always_comb begin
        rd_data = stat_byte;
        for (int i = 0; i < STAT_IDX; i++)
            if (ptr == PTR_W'(i))
                rd_data = rw_flat[i];
    end

    assign stat_clr = rd_stb && (ptr == PTR_W'(STAT_IDX));
    // a new event in the clearing cycle survives the clear
    assign flags_d  = (flags & ~{FLAG_N{stat_clr}}) | flt_set_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags  <= '0;
            attn_n <= 1'b1;
        end else begin
            flags  <= flags_d;
            attn_n <= ~(|flags_d);
        end
    end
endmodule

// File: rtl/i2cs_proto_fsm.sv
module i2cs_proto_fsm
    import i2cs_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_rise,
    input  logic               scl_fall,
    input  logic               start_det,
    input  logic               stop_det,
    input  logic               sda_s,
    input  logic [DADDR_W-1:0] dev_addr,
    input  logic [BYTE_W-1:0]  rd_data,
    output logic               sda_oe,
    output logic               wr_en,
    output logic               rd_stb,
    output logic [PTR_W-1:0]   ptr,
    output logic [BYTE_W-1:0]  shreg,
    output bus_st_t            state
);
    bus_st_t           state_d;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-2:0] tx;
    logic              rw_q;
    logic              mack_q;
    logic              byte_done;
    logic              addr_hit;
    logic              shifting;

    assign byte_done = scl_fall && (bit_cnt == CNT_W'(BYTE_W));
    assign addr_hit  = (shreg[BYTE_W-1:1] == dev_addr);
    assign shifting  = (state == ST_DEV) || (state == ST_PTR) ||
                       (state == ST_WR)  || (state == ST_RD);
    assign wr_en     = (state == ST_WR) && byte_done;
    assign rd_stb    = scl_fall && (((state == ST_DEV_ACK) && rw_q) ||
                                    ((state == ST_RD_ACK) && mack_q));

    // next-state logic
    always_comb begin
        state_d = state;
        if (start_det)
            state_d = ST_DEV;
        else if (stop_det)
            state_d = ST_IDLE;
        else begin
            unique case (state)
                ST_IDLE:    state_d = ST_IDLE;
                ST_SKIP:    state_d = ST_SKIP;
                ST_DEV:     if (byte_done) state_d = addr_hit ? ST_DEV_ACK : ST_SKIP;
                ST_DEV_ACK: if (scl_fall)  state_d = rw_q ? ST_RD : ST_PTR;
                ST_PTR:     if (byte_done) state_d = ST_PTR_ACK;
                ST_PTR_ACK: if (scl_fall)  state_d = ST_WR;
                ST_WR:      if (byte_done) state_d = ST_WR_ACK;
                ST_WR_ACK:  if (scl_fall)  state_d = ST_WR;
                ST_RD:      if (byte_done) state_d = ST_RD_ACK;
                ST_RD_ACK:  if (scl_fall)  state_d = mack_q ? ST_RD : ST_SKIP;
                default:    state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_d;
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
            tx      <= '0;
            rw_q    <= 1'b0;
            mack_q  <= 1'b0;
            ptr     <= '0;
            sda_oe  <= 1'b0;
        end else if (start_det || stop_det) begin
            bit_cnt <= '0;
            sda_oe  <= 1'b0;
        end else begin
            if (scl_rise) begin
                if (shifting) begin
                    shreg   <= {shreg[BYTE_W-2:0], sda_s};
                    bit_cnt <= bit_cnt + 1'b1;
                end
                if (state == ST_RD_ACK)
                    mack_q <= ~sda_s;
            end
            if (scl_fall) begin
                unique case (state)
                    ST_DEV: begin
                        if (byte_done && addr_hit) begin
                            sda_oe <= 1'b1;
                            rw_q   <= shreg[0];
                        end
                    end
                    ST_DEV_ACK, ST_RD_ACK: begin
                        bit_cnt <= '0;
                        if (rd_stb) begin
                            tx     <= rd_data[BYTE_W-2:0];
                            sda_oe <= ~rd_data[BYTE_W-1];
                            ptr    <= ptr + 1'b1;
                        end else begin
                            sda_oe <= 1'b0;
                        end
                    end
                    ST_PTR: begin
                        if (byte_done) begin
                            ptr    <= shreg[PTR_W-1:0];
                            sda_oe <= 1'b1;
                        end
                    end
                    ST_PTR_ACK, ST_WR_ACK: begin
                        bit_cnt <= '0;
                        sda_oe  <= 1'b0;
                    end
                    ST_WR: begin
                        if (byte_done) begin
                            ptr    <= ptr + 1'b1;
                            sda_oe <= 1'b1;
                        end
                    end
                    ST_RD: begin
                        if (byte_done) begin
                            sda_oe <= 1'b0;
                        end else begin
                            sda_oe <= ~tx[BYTE_W-2];
                            tx     <= {tx[BYTE_W-3:0], 1'b0};
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/i2c_regmap_slave.sv
module i2c_regmap_slave
    import i2cs_pkg::*;
#(
    parameter logic [DADDR_W-SEL_W-1:0] ADDR_BASE   = 5'b01100,
    parameter int unsigned              SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  addr_sel_i,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic              run_i,
    input  logic [FLAG_N-1:0] flt_set_i,
    output logic [BYTE_W-1:0] cmd_o,
    output logic [BYTE_W-1:0] dim_o,
    output logic [BYTE_W-1:0] aux_o,
    output logic              attn_n_o
);
    logic               scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic               wr_en, rd_stb;
    logic [PTR_W-1:0]   cur_ptr;
    logic [BYTE_W-1:0]  shreg, rd_data;
    logic [FLAG_N-1:0]  flags;
    logic [DADDR_W-1:0] dev_addr;
    bus_st_t            bus_state;

    assign dev_addr = {ADDR_BASE, addr_sel_i};

    i2cs_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2cs_proto_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det), .sda_s(sda_s),
        .dev_addr(dev_addr), .rd_data(rd_data), .sda_oe(sda_oe_o),
        .wr_en(wr_en), .rd_stb(rd_stb), .ptr(cur_ptr), .shreg(shreg),
        .state(bus_state)
    );

    i2cs_regfile u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .ptr(cur_ptr),
        .wr_data(shreg), .rd_stb(rd_stb), .run_i(run_i), .flt_set_i(flt_set_i),
        .rd_data(rd_data), .cmd_q(cmd_o), .dim_q(dim_o), .aux_q(aux_o),
        .flags(flags), .attn_n(attn_n_o)
    );
endmodule

// File: rtl/i2cs_checker.sv
module i2cs_checker
    import i2cs_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              scl_s,
    input logic              sda_oe,
    input logic              attn_n,
    input logic [BYTE_W-1:0] cmd,
    input logic [FLAG_N-1:0] flags,
    input logic              wr_en,
    input logic              rd_stb,
    input logic [PTR_W-1:0]  ptr,
    input bus_st_t           state
);
    // R2: the address acknowledge is held for the whole acknowledge state
    a_r2_ack_held: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DEV_ACK) |-> sda_oe);

    // R3: a slave that skips the transfer never pulls the data line
    a_r3_skip_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SKIP) |-> !sda_oe);

    // R4: the command register only moves on a data write aimed at pointer 0
    a_r4_cmd_write_only: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cmd) |-> $past(wr_en && ptr == '0));

    // R6: the slave changes the data line only while the clock line is low
    a_r6_sda_when_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_s);

    // R10: a latched flag drops only after a read of the status register
    a_r10_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(flags) & ~flags)) |-> $past(rd_stb && ptr == PTR_W'(STAT_IDX)));

    // R11: attention is released only by a status read
    a_r11_attn_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(attn_n) |-> $past(rd_stb && ptr == PTR_W'(STAT_IDX)));
endmodule

bind i2c_regmap_slave i2cs_checker u_chk (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe_o),
    .attn_n(attn_n_o), .cmd(cmd_o), .flags(flags), .wr_en(wr_en),
    .rd_stb(rd_stb), .ptr(cur_ptr), .state(bus_state)
);

// File: tb/sim_i2c_regmap_slave.sv
`timescale 1ns/1ps
module sim_i2c_regmap_slave;
    typedef logic [7:0] bq_t[$];
    localparam int Q = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic [1:0] sel = 2'd0;
    logic       run = 1'b0;
    logic [4:0] fset = 5'd0;
    logic       sda_oe, sda_line, attn_n;
    logic [7:0] cmd, dim, aux;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] got_b;
    event       got_ev;

    assign sda_line = m_sda & ~sda_oe;

    always #4 clk = ~clk;

    i2c_regmap_slave u0 (
        .clk(clk), .rst_n(rst_n), .addr_sel_i(sel), .scl_i(m_scl), .sda_i(sda_line),
        .sda_oe_o(sda_oe), .run_i(run), .flt_set_i(fset), .cmd_o(cmd), .dim_o(dim),
        .aux_o(aux), .attn_n_o(attn_n)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic expect_b(input logic [7:0] v, input string tag);
        exp_q.push_back(v);
        tag_q.push_back(tag);
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(got_ev);
            if (exp_q.size() == 0) begin
                chk(1'b0, "SB unexpected byte", {24'd0, got_b}, 32'd0);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(got_b == e, t, {24'd0, got_b}, {24'd0, e});
            end
        end
    end

    task automatic qw();
        repeat (Q) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        m_sda = 1'b1; qw();
        m_scl = 1'b1; qw();
        m_sda = 1'b0; qw();
        m_scl = 1'b0; qw();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; qw();
        m_scl = 1'b1; qw();
        m_sda = 1'b1; qw();
    endtask

    task automatic put_bit(input logic b);
        m_sda = b;    qw();
        m_scl = 1'b1; qw();
        m_scl = 1'b0; qw();
    endtask

    task automatic send_byte(input logic [7:0] v, output bit ack);
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        m_sda = 1'b1; qw();
        m_scl = 1'b1; qw();
        ack = ~sda_line;
        m_scl = 1'b0; qw();
    endtask

    task automatic get_byte(input bit mack, output logic [7:0] v);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            qw();
            m_scl = 1'b1; qw();
            v[i] = sda_line;
            m_scl = 1'b0;
        end
        qw();
        m_sda = ~mack; qw();
        m_scl = 1'b1;  qw();
        m_scl = 1'b0;  qw();
        m_sda = 1'b1;
    endtask

    task automatic wr_burst(input logic [6:0] a, input logic [7:0] p, input bq_t d, output bit acked);
        bit k;
        acked = 1'b1;
        bus_start();
        send_byte({a, 1'b0}, k); acked &= k;
        send_byte(p, k);         acked &= k;
        foreach (d[i]) begin
            send_byte(d[i], k);
            acked &= k;
        end
        bus_stop();
    endtask

    task automatic rd_burst(input logic [6:0] a, input bit set_ptr, input logic [7:0] p,
                            input int n, output bit acked);
        bit k;
        logic [7:0] v;
        acked = 1'b1;
        bus_start();
        if (set_ptr) begin
            send_byte({a, 1'b0}, k); acked &= k;
            send_byte(p, k);         acked &= k;
            bus_start();
        end
        send_byte({a, 1'b1}, k); acked &= k;
        for (int i = 0; i < n; i++) begin
            get_byte(i < n - 1, v);
            got_b = v;
            ->got_ev;
        end
        chk(sda_oe == 1'b0, "R6 SDA released after NACK", {31'd0, sda_oe}, 32'd0);
        bus_stop();
    endtask

    task automatic pulse_fault(input logic [4:0] f);
        fset = f;
        @(posedge clk); #1;
        fset = 5'd0;
        repeat (4) @(posedge clk); #1;
    endtask

    initial begin
        bit ok;
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (3) @(posedge clk); #1;

        // R1 reset state
        chk(cmd == 8'h00 && dim == 8'h00 && aux == 8'h00, "R1 registers cleared", {8'd0, cmd, dim, aux}, 32'd0);
        chk(attn_n == 1'b1, "R1 attention idle high", {31'd0, attn_n}, 32'd1);
        chk(sda_oe == 1'b0, "R1 SDA released", {31'd0, sda_oe}, 32'd0);

        // R2 and R4: single write, MSB-first pattern that is not bit-symmetric
        wr_burst(7'h30, 8'h00, '{8'hC1}, ok);
        chk(ok, "R2 address 0x30 acknowledged", {31'd0, ok}, 32'd1);
        chk(cmd == 8'hC1, "R4 command written MSB first", {24'd0, cmd}, 32'hC1);

        // R5 and R8: burst from pointer 1 passes the status slot and wraps to 0
        wr_burst(7'h30, 8'h01, '{8'h12, 8'h34, 8'h56, 8'h78}, ok);
        chk(ok, "R5 burst acknowledged", {31'd0, ok}, 32'd1);
        chk(dim == 8'h12 && aux == 8'h34, "R5 auto-increment dim/aux", {16'd0, dim, aux}, 32'h1234);
        chk(cmd == 8'h78, "R5 wrap 3 to 0 after status write (R8)", {24'd0, cmd}, 32'h78);

        // R6: burst read with repeated START
        expect_b(8'h78, "R6 read cmd");
        expect_b(8'h12, "R6 read dim");
        expect_b(8'h34, "R6 read aux");
        rd_burst(7'h30, 1'b1, 8'h00, 3, ok);
        chk(ok, "R6 read phases acknowledged", {31'd0, ok}, 32'd1);

        // R7 and R8: no pointer phase, pointer now 3, status shows no written bits
        expect_b(8'h00, "R8 status ignored write");
        rd_burst(7'h30, 1'b0, 8'h00, 1, ok);
        expect_b(8'h78, "R7 pointer kept and wrapped");
        rd_burst(7'h30, 1'b0, 8'h00, 1, ok);

        // R5: upper pointer bits are ignored
        wr_burst(7'h30, 8'h41, '{8'h9A}, ok);
        chk(dim == 8'h9A, "R5 pointer low bits only", {24'd0, dim}, 32'h9A);

        // R3: address mismatch
        wr_burst(7'h31, 8'h00, '{8'hFF}, ok);
        chk(!ok, "R3 no acknowledge for 0x31", {31'd0, ok}, 32'd0);
        chk(cmd == 8'h78, "R3 register untouched", {24'd0, cmd}, 32'h78);

        // R2: the other strap options
        for (int s = 1; s < 4; s++) begin
            sel = 2'(s);
            wr_burst(7'h30 | 7'(s), 8'h02, '{8'h40 + 8'(s)}, ok);
            chk(ok, "R2 strapped address acknowledged", {31'd0, ok}, 32'd1);
            chk(aux == 8'h40 + 8'(s), "R2 strapped write landed", {24'd0, aux}, 32'h40 + s);
        end
        wr_burst(7'h30, 8'h02, '{8'hEE}, ok);
        chk(!ok && aux == 8'h43, "R3 base address refused with strap 3", {23'd0, ok, aux}, 32'h43);
        sel = 2'd0;

        // R9, R10, R11: latching, layout, clearing and attention
        run = 1'b1;
        pulse_fault(5'b10010);
        chk(attn_n == 1'b0, "R11 attention asserted", {31'd0, attn_n}, 32'd0);
        pulse_fault(5'b00001);
        expect_b(8'h65, "R9 status layout");
        rd_burst(7'h30, 1'b1, 8'h03, 1, ok);
        chk(attn_n == 1'b1, "R11 attention released by status read", {31'd0, attn_n}, 32'd1);
        expect_b(8'h40, "R10 flags cleared by read");
        rd_burst(7'h30, 1'b1, 8'h03, 1, ok);

        // R10: set held across the clearing read wins
        fset = 5'b01100;
        repeat (3) @(posedge clk); #1;
        expect_b(8'h58, "R10 set during read");
        rd_burst(7'h30, 1'b1, 8'h03, 1, ok);
        fset = 5'd0;
        repeat (3) @(posedge clk); #1;
        chk(attn_n == 1'b0, "R10 set wins over clear", {31'd0, attn_n}, 32'd0);
        expect_b(8'h58, "R10 flags still latched");
        rd_burst(7'h30, 1'b1, 8'h03, 1, ok);
        run = 1'b0;
        repeat (3) @(posedge clk); #1;
        expect_b(8'h00, "R9 run bit is live");
        rd_burst(7'h30, 1'b1, 8'h03, 1, ok);
        chk(attn_n == 1'b1, "R11 attention high after clear", {31'd0, attn_n}, 32'd1);

        // R12: STOP inside a data byte discards it
        bus_start();
        send_byte(8'h60, ok);
        send_byte(8'h00, ok);
        put_bit(1'b0); put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
        bus_stop();
        chk(cmd == 8'h78, "R12 partial byte discarded", {24'd0, cmd}, 32'h78);

        chk(exp_q.size() == 0, "SB all expected bytes seen", exp_q.size(), 32'd0);

        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            chk(1'b0, "watchdog expired", 32'd0, 32'd1);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule